// File: doc/BRIEF.md
# Up-Counting Timer with Shared-Address Capture Register

This block is an up-counting timer that has a programmable period compare and a capture register. The capture register shares one bus read address with the live counter. A read-select input picks what that address returns: either the raw count, or the value held in the capture register. The capture register is loaded from the counter by three sources:
- a software capture pulse;
- a stop event;
- an edge on an external source, when no stop condition is configured. The active edge polarity is selectable.

Software can load the counter through the shared address only while the timer is off. A clear pulse zeroes the counter at any time and never disturbs the captured value. The counter advances on a tick qualifier while the run state is set. It can either roll over at its full width or return to zero on the tick after it reaches the period value.

All command inputs are single-cycle pulses in the timer clock domain. Configuration inputs are levels. The counter width is a parameter, with a default of 16 bits. A second parameter removes the external-edge capture path.

Top module: `tcu_timer_capture`

## Requirements
- R1: After reset the count is 0, the captured value is 0 and the run state is off.
- R2: While running, each cycle with `tick_i`=1 steps the count by one. The first tick from 0 gives 1. With reset-at-period off, the count rolls from all-ones to 0.
- R3: With `wrap_at_period_i`=1, a tick while the count equals `period_i` gives 0. `period_match_o` is 1 exactly while the count equals `period_i`.
- R4: `rd_data_o` shows the count when `rd_sel_i`=1 and the captured value when `rd_sel_i`=0.
- R5: A write (`wr_en_i`=1) loads `wr_data_i` into the count only when `rd_sel_i`=1 and the timer is off. Otherwise it leaves the count unchanged.
- R6: `clr_cmd_i` zeroes the count on the next edge, even while running. It wins over a write and a tick, and it leaves the captured value unchanged.
- R7: `capt_cmd_i` loads the captured value with the count as it stood before that edge. This includes a cycle in which a clear or a tick also occurs.
- R8: With `stop_none_i`=0, `stop_evt_i` loads the capture with the current count and turns the run state off on the same edge, with no tick applied. With `stop_none_i`=1, `stop_evt_i` is ignored.
- R9: With `stop_none_i`=1, an edge on `ext_src_i` loads the capture. The edge is rising when `edge_fall_i`=0 and falling when `edge_fall_i`=1. Each new edge overwrites the previous value. With `stop_none_i`=0, edges are ignored.
- R10: `run_start_i` sets the run state. `run_halt_i` clears it. A halt or an honoured stop event wins over a start in the same cycle. `running_o` shows the state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_start_i | input | 1 | Pulse: set run state |
| run_halt_i | input | 1 | Pulse: clear run state |
| stop_evt_i | input | 1 | Pulse: stop event (capture and halt) |
| tick_i | input | 1 | Count qualifier |
| capt_cmd_i | input | 1 | Pulse: software capture |
| clr_cmd_i | input | 1 | Pulse: clear counter |
| rd_sel_i | input | 1 | 1 = shared address maps to counter, 0 = capture |
| edge_fall_i | input | 1 | External capture edge: 0 rising, 1 falling |
| stop_none_i | input | 1 | 1 = no stop condition configured |
| wrap_at_period_i | input | 1 | 1 = return to zero after period match |
| period_i | input | CNT_W | Period compare value |
| ext_src_i | input | 1 | External event source (synchronous) |
| wr_en_i | input | 1 | Bus write strobe to shared address |
| wr_data_i | input | CNT_W | Bus write data |
| rd_data_o | output | CNT_W | Bus read data from shared address |
| running_o | output | 1 | Run state |
| period_match_o | output | 1 | Count equals period |

## Verification
The bench runs a 4-bit counter through every period value in reset-at-period mode and through full-width rollover, so a wrong wrap comparison or an off-by-one on the first tick shows up as a skipped or repeated value. It drives the collision cases directly:
- capture together with clear, where a design that captured the post-clear value would read 0;
- a write while running, which must leave the count intact;
- a start together with a stop event, which must leave the timer off.

External edges are swept over both polarities and with the stop condition set both ways. A design with the polarity inverted, or one that ignored the stop-condition gate, would load the capture on the wrong cycles.

// File: rtl/tcu_pkg.sv
package tcu_pkg;

   typedef enum logic {
      TMR_IDLE = 1'b0,
      TMR_RUN  = 1'b1
   } run_state_e;

   typedef struct packed {
      logic rd_sel;
      logic edge_fall;
      logic stop_none;
      logic wrap_at_period;
   } tcu_cfg_t;

endpackage

// File: rtl/tcu_edge_detect.sv
module tcu_edge_detect #(
   parameter bit ENABLE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sig_i,
   input  logic fall_sel_i,
   output logic edge_o
);

   generate
      if (ENABLE) begin : g_detect
         logic prev_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) prev_q <= 1'b0;
            else        prev_q <= sig_i;
         end
         assign edge_o = fall_sel_i ? (prev_q & ~sig_i) : (~prev_q & sig_i);
      end else begin : g_absent
         logic unused_edge_inputs;
         assign unused_edge_inputs = ^{clk, rst_n, sig_i, fall_sel_i};
         assign edge_o = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/tcu_run_ctrl.sv
module tcu_run_ctrl
   import tcu_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   input  logic halt_i,
   input  logic stop_hit_i,
   output logic running_o
);

   run_state_e state_q, state_d;

   always_comb begin
      state_d = state_q;
      if (halt_i || stop_hit_i) state_d = TMR_IDLE;
      else if (start_i)         state_d = TMR_RUN;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= TMR_IDLE;
      else        state_q <= state_d;
   end

   assign running_o = (state_q == TMR_RUN);

endmodule

// File: rtl/tcu_counter.sv
module tcu_counter #(
   parameter int CNT_W = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance_i,
   input  logic             clr_i,
   input  logic             ld_i,
   input  logic [CNT_W-1:0] ld_data_i,
   input  logic             wrap_i,
   input  logic [CNT_W-1:0] period_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             match_o
);

   localparam logic [CNT_W-1:0] CNT_ZERO = '0;
   localparam logic [CNT_W-1:0] CNT_STEP = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_adv;
   logic             at_period;

   assign at_period = (cnt_q == period_i);

   always_comb begin
      if (wrap_i && at_period) cnt_adv = CNT_ZERO;
      else                     cnt_adv = cnt_q + CNT_STEP;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         cnt_q <= CNT_ZERO;
      else if (clr_i)     cnt_q <= CNT_ZERO;
      else if (ld_i)      cnt_q <= ld_data_i;
      else if (advance_i) cnt_q <= cnt_adv;
   end

   assign cnt_o   = cnt_q;
   assign match_o = at_period;

endmodule

// File: rtl/tcu_capture.sv
module tcu_capture #(
   parameter int CNT_W = 16,
   parameter int N_SRC = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_SRC-1:0] trig_i,
   input  logic [CNT_W-1:0] cnt_i,
   output logic [CNT_W-1:0] cap_o
);

   logic [CNT_W-1:0] cap_q;
   logic             load;

   assign load = |trig_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    cap_q <= '0;
      else if (load) cap_q <= cnt_i;
   end

   assign cap_o = cap_q;

endmodule

// File: rtl/tcu_timer_capture.sv
module tcu_timer_capture
   import tcu_pkg::*;
#(
   parameter int CNT_W          = 16,
   parameter bit EXT_CAPTURE_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run_start_i,
   input  logic             run_halt_i,
   input  logic             stop_evt_i,
   input  logic             tick_i,
   input  logic             capt_cmd_i,
   input  logic             clr_cmd_i,
   input  logic             rd_sel_i,
   input  logic             edge_fall_i,
   input  logic             stop_none_i,
   input  logic             wrap_at_period_i,
   input  logic [CNT_W-1:0] period_i,
   input  logic             ext_src_i,
   input  logic             wr_en_i,
   input  logic [CNT_W-1:0] wr_data_i,
   output logic [CNT_W-1:0] rd_data_o,
   output logic             running_o,
   output logic             period_match_o
);

   localparam int N_SRC   = 3;
   localparam int SRC_CMD = 0;
   localparam int SRC_STP = 1;
   localparam int SRC_EXT = 2;

   generate
      if (CNT_W < 2 || CNT_W > 32) begin : g_bad_width
         $error("tcu_timer_capture: CNT_W must lie in 2..32");
      end
   endgenerate

   tcu_cfg_t cfg;
   assign cfg = '{rd_sel: rd_sel_i, edge_fall: edge_fall_i,
                  stop_none: stop_none_i, wrap_at_period: wrap_at_period_i};

   logic             running;
   logic             stop_hit;
   logic             ext_edge;
   logic             ext_hit;
   logic             advance;
   logic             wr_ok;
   logic [CNT_W-1:0] cnt_w;
   logic [CNT_W-1:0] cap_w;
   logic [N_SRC-1:0] cap_trig;

   assign stop_hit = stop_evt_i & ~cfg.stop_none;
   assign ext_hit  = ext_edge & cfg.stop_none;
   assign advance  = running & tick_i & ~stop_hit;
   assign wr_ok    = wr_en_i & cfg.rd_sel & ~running;

   always_comb begin
      cap_trig          = '0;
      cap_trig[SRC_CMD] = capt_cmd_i;
      cap_trig[SRC_STP] = stop_hit;
      cap_trig[SRC_EXT] = ext_hit;
   end

   tcu_edge_detect #(.ENABLE(EXT_CAPTURE_EN)) u_edge (
      .clk        (clk),
      .rst_n      (rst_n),
      .sig_i      (ext_src_i),
      .fall_sel_i (cfg.edge_fall),
      .edge_o     (ext_edge)
   );

   tcu_run_ctrl u_run (
      .clk        (clk),
      .rst_n      (rst_n),
      .start_i    (run_start_i),
      .halt_i     (run_halt_i),
      .stop_hit_i (stop_hit),
      .running_o  (running)
   );

   tcu_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk       (clk),
      .rst_n     (rst_n),
      .advance_i (advance),
      .clr_i     (clr_cmd_i),
      .ld_i      (wr_ok),
      .ld_data_i (wr_data_i),
      .wrap_i    (cfg.wrap_at_period),
      .period_i  (period_i),
      .cnt_o     (cnt_w),
      .match_o   (period_match_o)
   );

   tcu_capture #(.CNT_W(CNT_W), .N_SRC(N_SRC)) u_cap (
      .clk    (clk),
      .rst_n  (rst_n),
      .trig_i (cap_trig),
      .cnt_i  (cnt_w),
      .cap_o  (cap_w)
   );

   assign rd_data_o = cfg.rd_sel ? cnt_w : cap_w;
   assign running_o = running;

endmodule

// File: rtl/tcu_timer_capture_chk.sv
module tcu_timer_capture_chk #(
   parameter int CNT_W = 16
) (
   input logic             clk,
   input logic             rst_n,
   input logic             running,
   input logic             tick_i,
   input logic             clr_cmd_i,
   input logic             capt_cmd_i,
   input logic             stop_evt_i,
   input logic             stop_none_i,
   input logic             wrap_at_period_i,
   input logic             ext_edge,
   input logic [CNT_W-1:0] period_i,
   input logic [CNT_W-1:0] cnt_w,
   input logic [CNT_W-1:0] cap_w
);

   logic stop_h;
   assign stop_h = stop_evt_i & ~stop_none_i;

   assert_count_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (running && tick_i && !stop_h && !clr_cmd_i &&
       !(wrap_at_period_i && cnt_w == period_i))
      |=> cnt_w == $past(cnt_w) + CNT_W'(1));

   assert_wrap_at_period_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (running && tick_i && !stop_h && !clr_cmd_i &&
       wrap_at_period_i && cnt_w == period_i) |=> cnt_w == '0);

   assert_hold_while_running_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (running && !tick_i && !clr_cmd_i) |=> $stable(cnt_w));

   assert_clear_zeroes_R6: assert property (@(posedge clk) disable iff (!rst_n)
      clr_cmd_i |=> cnt_w == '0);

   assert_clear_keeps_capture_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_cmd_i && !capt_cmd_i && !stop_h && !(ext_edge && stop_none_i))
      |=> $stable(cap_w));

   assert_capture_cmd_R7: assert property (@(posedge clk) disable iff (!rst_n)
      capt_cmd_i |=> cap_w == $past(cnt_w));

   assert_stop_event_R8: assert property (@(posedge clk) disable iff (!rst_n)
      stop_h |=> (!running && cap_w == $past(cnt_w)));

   assert_ext_gated_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!stop_none_i && !capt_cmd_i && !stop_evt_i) |=> $stable(cap_w));

endmodule

bind tcu_timer_capture tcu_timer_capture_chk #(.CNT_W(CNT_W)) u_chk (
   .clk              (clk),
   .rst_n            (rst_n),
   .running          (running),
   .tick_i           (tick_i),
   .clr_cmd_i        (clr_cmd_i),
   .capt_cmd_i       (capt_cmd_i),
   .stop_evt_i       (stop_evt_i),
   .stop_none_i      (stop_none_i),
   .wrap_at_period_i (wrap_at_period_i),
   .ext_edge         (ext_edge),
   .period_i         (period_i),
   .cnt_w            (cnt_w),
   .cap_w            (cap_w)
);

// File: tb/test_tcu_timer_capture.sv
`timescale 1ns/1ps
module test_tcu_timer_capture;

   localparam int W = 4;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         run_start = 0, run_halt = 0, stop_evt = 0, tick = 0;
   logic         capt = 0, clr = 0, rd_sel = 1, edge_fall = 0;
   logic         stop_none = 1, wrap = 0, ext = 0, wr_en = 0;
   logic [W-1:0] period = '0, wr_data = '0;
   logic [W-1:0] rd_data;
   logic         running, pmatch;

   logic [W-1:0] m_cnt = '0, m_cap = '0;
   logic         m_on = 1'b0, m_prev = 1'b0;
   int           n_chk = 0, n_bad = 0;

   always #4 clk = ~clk;

   tcu_timer_capture #(.CNT_W(W)) i_tcu_timer_capture (
      .clk(clk), .rst_n(rst_n), .run_start_i(run_start), .run_halt_i(run_halt),
      .stop_evt_i(stop_evt), .tick_i(tick), .capt_cmd_i(capt), .clr_cmd_i(clr),
      .rd_sel_i(rd_sel), .edge_fall_i(edge_fall), .stop_none_i(stop_none),
      .wrap_at_period_i(wrap), .period_i(period), .ext_src_i(ext),
      .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
      .running_o(running), .period_match_o(pmatch));

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   // Reads both views of the shared address (R4), run state and match flag.
   task automatic verify(input string req);
      logic keep;
      keep = rd_sel;
      rd_sel = 1'b1; #0.5;
      chk(req, "count view (R4)", int'(rd_data), int'(m_cnt));
      rd_sel = 1'b0; #0.5;
      chk(req, "capture view (R4)", int'(rd_data), int'(m_cap));
      rd_sel = keep; #0.1;
      chk(req, "running", int'(running), int'(m_on));
      chk(req, "period match (R3)", int'(pmatch), int'(m_cnt == period));
   endtask

   // One clock: reference update from the requirements, then edge, then pulse release.
   task automatic step();
      logic         stop_h, ext_h;
      logic [W-1:0] cn;
      stop_h = stop_evt && !stop_none;
      ext_h  = stop_none && (edge_fall ? (m_prev && !ext) : (!m_prev && ext));
      if (clr)                              cn = '0;
      else if (wr_en && rd_sel && !m_on)    cn = wr_data;
      else if (m_on && tick && !stop_h)     cn = (wrap && m_cnt == period) ? '0 : W'(m_cnt + 1);
      else                                  cn = m_cnt;
      if (capt || stop_h || ext_h) m_cap = m_cnt;
      if (stop_h || run_halt)  m_on = 1'b0;
      else if (run_start)      m_on = 1'b1;
      m_cnt  = cn;
      m_prev = ext;
      @(posedge clk); #1;
      run_start = 0; run_halt = 0; stop_evt = 0; capt = 0; clr = 0; wr_en = 0;
   endtask

   initial begin
      #800000;
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      verify("R1");
      chk("R1", "count after reset", int'(m_cnt), 0);

      // R5: write while off with counter selected, then with capture selected
      rd_sel = 1; wr_en = 1; wr_data = 4'd9; step(); verify("R5");
      rd_sel = 0; wr_en = 1; wr_data = 4'd3; step(); verify("R5");
      rd_sel = 1;

      // R6: clear wins over write
      clr = 1; wr_en = 1; wr_data = 4'd7; step(); verify("R6");

      // R2: free-running rollover, first tick 0 -> 1
      period = 4'd15; wrap = 0; run_start = 1; step(); verify("R10");
      tick = 1;
      for (int i = 0; i < 20; i++) begin step(); verify("R2"); end
      tick = 0;

      // R5: write while running is ignored
      wr_en = 1; wr_data = 4'd2; step(); verify("R5");

      // R3: every period in reset-at-period mode
      for (int p = 0; p < 16; p++) begin
         run_halt = 1; clr = 1; step();
         period = 4'(p); wrap = 1; run_start = 1; step(); verify("R3");
         tick = 1;
         for (int i = 0; i < 18; i++) begin step(); verify("R3"); end
         tick = 0;
      end

      // R7: capture at several counts, with tick, and together with clear
      wrap = 0; period = 4'd15; tick = 1;
      for (int i = 0; i < 6; i++) begin
         capt = (i % 2 == 1); step(); verify("R7");
      end
      capt = 1; clr = 1; step(); verify("R7");
      chk("R6", "capture survives clear", int'(m_cap) == 0 ? 1 : 0, 0);
      step(); clr = 1; step(); verify("R6");
      tick = 0;

      // R8: stop event honoured and ignored
      tick = 1; step(); step(); step();
      stop_none = 0; stop_evt = 1; step(); verify("R8");
      run_start = 1; step(); step(); verify("R8");
      stop_none = 1; stop_evt = 1; step(); verify("R8");
      stop_none = 0; stop_evt = 1; run_start = 1; step(); verify("R10");
      run_start = 1; step(); step(); verify("R10");

      // R9: external edges, both polarities, gated by stop condition
      for (int pol = 0; pol < 2; pol++) begin
         edge_fall = pol[0];
         for (int sn = 0; sn < 2; sn++) begin
            stop_none = sn[0];
            for (int i = 0; i < 6; i++) begin
               ext = ~ext; step(); verify("R9");
               step(); verify("R9");
            end
         end
      end
      tick = 0;
      run_halt = 1; step(); verify("R10");

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule